// File: doc/BRIEF.md
# Gated 16-bit Event Timer with Prescaler

This block is a 16-bit up-counter kept as a low byte and a high byte. It counts rising edges of an external timer clock input. That input first passes through a selectable two-flop synchroniser or a direct path, then a divide-by-1/2/4/8 prescaler. A level gate of selectable polarity can decide whether the count runs. When the count wraps from all ones to zero, an overflow flag is raised. The flag stays raised until a clear strobe removes it.

Software reaches the block through a byte-wide register bus with three registers: the low count byte, the high count byte and a control register. The write path has no handshake and the read data is combinational from the address. Everything runs on one system clock. A rising timer-clock edge is turned into a one-cycle enable pulse. A common use is the start-up delay of a slow oscillator: load FC00h, clear the flag, and wait for the flag, which rises after 1024 counted edges.

Top module: `gate_tmr16`

## Requirements
- R1: After reset the low byte, the high byte and the control register all read 00h, and the overflow flag is 0.
- R2: Address 0 selects the low count byte, address 1 the high count byte, and address 2 the control register. Control bit 0 is run, bits 2:1 are the prescale select, bit 3 is gate enable, bit 4 is gate polarity and bit 5 is direct (unsynchronised) clock mode. Bits 7:6 read as 0.
- R3: While run is 0, no timer clock edge changes the count, but bus writes and reads of both count bytes still work.
- R4: Prescale select 0, 1, 2 and 3 make the count advance once per 1, 2, 4 and 8 qualified timer clock rising edges.
- R5: A write to either count byte clears the hidden prescale counter, so a full prescale period of edges is needed before the next increment.
- R6: With gate enable 0 every prescaled edge is counted, whatever the gate input level.
- R7: With gate enable 1 and polarity 1, edges are counted while the gate input is 1 and the count holds while it is 0.
- R8: With gate enable 1 and polarity 0, edges are counted while the gate input is 0 and the count holds while it is 1.
- R9: In both synchronised and direct mode, each rising edge of the timer clock input is counted exactly once, however long the input stays high.
- R10: A counted edge at FFFFh gives 0000h and sets the overflow flag. Loading FC00h sets the flag after exactly 1024 counted edges.
- R11: The overflow flag stays set until the clear input is pulsed. A clear in the same cycle as a wrap leaves the flag set.
- R12: A bus write to a count byte in the same cycle as an increment takes priority. The written byte takes the bus data, the other byte is unchanged, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 low, 1 high, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| tck_in | input | 1 | Timer clock input (level) |
| gate_in | input | 1 | Gate level input |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can fall in the same cycle: a bus write to a count byte with a counted edge, and a flag clear with a wrap. Both are provoked in direct clock mode, where a rising level on the timer input is counted at the very next system clock edge. That lets the bench raise the input and the write or clear strobe on the same falling edge. The result is judged on the ports. After the write collision the written byte holds the bus data and the other byte is unchanged. After the clear collision the count reads zero and the flag still reads 1.

// File: rtl/gate_tmr16_pkg.sv
package gate_tmr16_pkg;

  typedef enum logic [1:0] {
    RA_LOW  = 2'd0,
    RA_HIGH = 2'd1,
    RA_CTRL = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // First member is the most significant bit: bit5 .. bit0
  typedef struct packed {
    logic       direct_clk;
    logic       gate_pol;
    logic       gate_en;
    logic [1:0] div_sel;
    logic       run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  // Last prescale count value before an increment is released.
  function automatic logic [7:0] div_last(input logic [1:0] sel);
    return 8'((1 << sel) - 1);
  endfunction

  // Gate decision: open when gating is off or the level matches polarity.
  function automatic logic gate_passes(input logic en, input logic pol,
                                       input logic lvl);
    return !en || (lvl == pol);
  endfunction

endpackage

// File: rtl/tmr_clk_front.sv
module tmr_clk_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_raw,
  input  logic direct_clk,
  output logic tck_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;
  logic                   sync_pulse;
  logic                   raw_pulse;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= tck_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_prev_q  <= tck_raw;
    end
  end

  assign sync_pulse = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign raw_pulse  = tck_raw & ~raw_prev_q;
  assign tck_pulse  = direct_clk ? raw_pulse : sync_pulse;

  AST_SYNC_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse); // R9
  AST_RAW_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    raw_pulse |=> !raw_pulse); // R9

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import gate_tmr16_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       clr,
  input  logic [1:0] div_sel,
  output logic       tick
);

  logic [PS_W-1:0] ps_q;
  logic            at_last;

  assign at_last = ps_q >= PS_W'(div_last(div_sel));
  assign tick    = adv & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (clr)     ps_q <= '0;
    else if (adv)     ps_q <= at_last ? '0 : ps_q + 1'b1;
  end

  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ps_q == '0); // R5
  AST_PS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !clr |=> $stable(ps_q)); // R3

endmodule

// File: rtl/tmr_count16.sv
module tmr_count16 #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  logic bus_hit;
  assign bus_hit = wr_lo | wr_hi;
  assign wrap    = tick & at_top(cnt) & ~bus_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (bus_hit) begin
      if (wr_lo) cnt[BYTE_W-1:0]     <= wdata;
      if (wr_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[BYTE_W-1:0] == $past(wdata)); // R12
  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && !wr_hi |=> cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W])); // R12
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !bus_hit |=> $stable(cnt)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R10

endmodule

// File: rtl/gate_tmr16.sv
module gate_tmr16
  import gate_tmr16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tck_in,
  input  logic              gate_in,
  input  logic              ovf_clr,
  output logic              ovf_flag
);

  tmr_ctrl_t        ctrl_q;
  logic             wr_lo, wr_hi, wr_ctrl;
  logic             tck_pulse;
  logic             gate_open;
  logic             ps_adv;
  logic             ps_tick;
  logic             cnt_wrap;
  logic [CNT_W-1:0] cnt;

  assign wr_lo   = bus_wr && (reg_addr_e'(bus_addr) == RA_LOW);
  assign wr_hi   = bus_wr && (reg_addr_e'(bus_addr) == RA_HIGH);
  assign wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == RA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  tmr_clk_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .tck_raw    (tck_in),
    .direct_clk (ctrl_q.direct_clk),
    .tck_pulse  (tck_pulse)
  );

  assign gate_open = gate_passes(ctrl_q.gate_en, ctrl_q.gate_pol, gate_in);
  assign ps_adv    = ctrl_q.run & tck_pulse & gate_open;

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (ps_adv),
    .clr     (wr_lo | wr_hi),
    .div_sel (ctrl_q.div_sel),
    .tick    (ps_tick)
  );

  tmr_count16 #(.BYTE_W(BYTE_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ps_tick),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (bus_wdata),
    .cnt   (cnt),
    .wrap  (cnt_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (cnt_wrap) ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_LOW:  bus_rdata = cnt[BYTE_W-1:0];
      RA_HIGH: bus_rdata = cnt[CNT_W-1:BYTE_W];
      RA_CTRL: bus_rdata = BYTE_W'(ctrl_q);
      default: bus_rdata = '0;
    endcase
  end

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> ovf_flag); // R10
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !cnt_wrap |=> !ovf_flag); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag); // R11
  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !ps_tick); // R3
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.gate_en && (gate_in != ctrl_q.gate_pol) |-> !ps_tick); // R7 R8

endmodule

// File: tb/gate_tmr16_bench.sv
module gate_tmr16_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tck_in = 1'b0;
  logic       gate_in = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       ovf_flag;

  always #5 clk = ~clk;

  gate_tmr16 u_gate_tmr16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tck_in    (tck_in),
    .gate_in   (gate_in),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
  );

  typedef struct {
    int         kind;   // 0..2 register read, 4 overflow flag
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  // Reference model state
  logic [15:0] m_cnt  = 16'h0000;
  int          m_ps   = 0;
  logic        m_flag = 1'b0;
  logic [7:0]  m_ctl  = 8'h00;

  // Monitor: compares one queued expectation per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it  = exp_q.pop_front();
        got = (it.kind == 4) ? {7'd0, ovf_flag} : bus_rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s got %02h expected %02h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input int a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = 2'(a);
    it.kind = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic expect_flag(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 4; it.exp = {7'd0, e}; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic expect_count(input string tag);
    expect_reg(0, m_cnt[7:0], tag);
    expect_reg(1, m_cnt[15:8], tag);
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 0) begin m_cnt[7:0] = d; m_ps = 0; end
    else if (a == 1) begin m_cnt[15:8] = d; m_ps = 0; end
    else if (a == 2) m_ctl = d & 8'h3F;
  endtask

  function automatic bit model_gate();
    if (!m_ctl[3]) return 1;
    return gate_in == m_ctl[4];
  endfunction

  task automatic model_edge();
    if (m_ctl[0] && model_gate()) begin
      m_ps++;
      if (m_ps >= (1 << m_ctl[2:1])) begin
        m_ps = 0;
        m_cnt = m_cnt + 16'd1;
        if (m_cnt == 16'h0000) m_flag = 1'b1;
      end
    end
  endtask

  task automatic tclks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tck_in = 1'b1;
      repeat (4) @(negedge clk);
      tck_in = 1'b0;
      repeat (3) @(negedge clk);
      model_edge();
    end
  endtask

  task automatic flag_clear();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    m_flag = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..R12 got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    expect_reg(0, 8'h00, "R1 low byte");
    expect_reg(1, 8'h00, "R1 high byte");
    expect_reg(2, 8'h00, "R1 control");
    expect_flag(1'b0, "R1 flag");

    // R2 control layout, upper bits read 0
    bus_write(2, 8'hFF);
    expect_reg(2, 8'h3F, "R2 control readback");
    expect_reg(3, 8'h00, "R2 unused address");
    bus_write(2, 8'h00);

    // R3 stopped timer ignores edges, bus still works
    tclks(3);
    expect_count("R3 stopped count");
    bus_write(0, 8'h34);
    bus_write(1, 8'h12);
    expect_count("R3 bus write while stopped");

    // R4 and R6: each divider, gate off with gate input either level
    bus_write(2, 8'h01);
    gate_in = 1'b0;
    tclks(5);
    expect_count("R4 R6 divide by 1");
    bus_write(2, 8'h03);
    gate_in = 1'b1;
    tclks(4);
    expect_count("R4 R6 divide by 2");
    bus_write(2, 8'h05);
    tclks(8);
    expect_count("R4 divide by 4");
    bus_write(2, 8'h07);
    bus_write(0, 8'h00);
    tclks(16);
    expect_count("R4 divide by 8");

    // R5 count write clears hidden prescaler
    bus_write(2, 8'h05);
    bus_write(0, 8'h00);
    tclks(2);
    bus_write(0, 8'h50);
    tclks(2);
    expect_count("R5 no increment after prescaler clear");
    tclks(2);
    expect_count("R5 increment after full period");

    // R7 gate polarity 1
    bus_write(2, 8'h19);
    gate_in = 1'b0;
    tclks(3);
    expect_count("R7 gate low holds");
    gate_in = 1'b1;
    tclks(3);
    expect_count("R7 gate high counts");

    // R8 gate polarity 0
    bus_write(2, 8'h09);
    tclks(3);
    expect_count("R8 gate high holds");
    gate_in = 1'b0;
    tclks(3);
    expect_count("R8 gate low counts");

    // R9 direct mode, one count per long-held edge
    bus_write(2, 8'h21);
    tclks(4);
    expect_count("R9 direct mode edges");
    bus_write(2, 8'h01);
    tclks(2);
    expect_count("R9 synchronised mode edges");

    // R10 FC00 start-up delay
    bus_write(1, 8'hFC);
    bus_write(0, 8'h00);
    tclks(1023);
    expect_flag(1'b0, "R10 flag not yet set after 1023");
    expect_count("R10 count at top");
    tclks(1);
    expect_flag(1'b1, "R10 flag after 1024");
    expect_count("R10 wrapped to zero");

    // R11 sticky flag and clear
    tclks(2);
    expect_flag(1'b1, "R11 flag sticky");
    flag_clear();
    expect_flag(1'b0, "R11 flag cleared");

    // R11 clear collides with wrap in direct mode
    bus_write(2, 8'h21);
    bus_write(1, 8'hFF);
    bus_write(0, 8'hFF);
    @(negedge clk);
    tck_in = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    tck_in = 1'b0; ovf_clr = 1'b0;
    m_cnt = 16'h0000; m_flag = 1'b1;
    repeat (2) @(negedge clk);
    expect_flag(1'b1, "R11 wrap beats clear");
    expect_count("R11 count wrapped in collision");
    flag_clear();
    expect_flag(1'b0, "R11 clear alone");

    // R12 write collides with increment in direct mode
    bus_write(1, 8'h00);
    bus_write(0, 8'hFF);
    @(negedge clk);
    tck_in = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h10;
    @(negedge clk);
    tck_in = 1'b0; bus_wr = 1'b0;
    m_cnt = 16'h0010; m_ps = 0;
    repeat (2) @(negedge clk);
    expect_reg(0, 8'h10, "R12 written byte kept");
    expect_reg(1, 8'h00, "R12 other byte unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule